// File: doc/BRIEF.md
# Split-Bank GPIO Controller with Atomic Set/Clear Registers

This block controls 32 general-purpose pins split into two halves of 16. The low half holds pins 0 to 15. The high half holds pins 16 to 31 and sits at a fixed word-address stride above the low half. Both halves have the same register layout. Each half holds eight 16-bit state registers:

- the pin output level;
- seven per-pin feature enables: input, output, open-drain, pull-up, pull-down, input inversion and output inversion.

Software changes any of these with a single 32-bit write, without reading first. The lower half of the written word marks pins whose feature turns on. The upper half marks pins whose feature turns off.

The pad cells are outside the block. The block presents them as enable and level signals: a drive enable and a drive level per pin, a pull-up request and a pull-down request per pin, and a raw pad input per pin. The block drives pins in push-pull or open-drain mode and can invert the output level. Input levels pass through a two-stage synchronizer, then an optional inversion, and are gated by the input enable.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Word address bit 4 selects the half: 0 is the low half (pins 0..15) and 1 is the high half (pins 16..31, pin p handled as bit p-16). Address bits 3:0 select the register within the half. Index 0 is the output level, 1 input enable, 2 output enable, 3 open-drain, 4 pull-up, 5 pull-down, 6 input invert and 7 output invert. A write to one half never alters the other half.
- R2: A write with bit n (0..15) of the data set turns on that register's bit for pin n.
- R3: A write with bit n+16 of the data set turns off that register's bit for pin n.
- R4: A pin whose set and clear bits are both 0 keeps its value. A write to an index from 8 to 15 changes no register and reads back as 0.
- R5: When one write asks both to set and to clear the same pin, the pin ends up cleared.
- R6: Reads are combinational. Data bits 15:0 return the addressed register with bit n giving pin n. Bits 31:16 read 0. The output-level register returns the programmed pin levels.
- R7: With output enable on and open-drain off, the pin is driven (`pad_oe`=1) and `pad_out` equals the output level XOR the output-invert bit.
- R8: With output enable and open-drain both on, an effective level of 0 drives low (`pad_oe`=1, `pad_out`=0). An effective level of 1 releases the pin (`pad_oe`=0).
- R9: With output enable off, `pad_oe` and `pad_out` are both 0 for that pin.
- R10: With input enable on, `pin_in` equals `pad_in` XOR the input-invert bit, after two clock edges of synchronization. The inversion applies at once, with no extra delay.
- R11: With input enable off, `pin_in` reads 0 whatever the pad does.
- R12: `pad_pu` and `pad_pd` follow the pull-up and pull-down register bits with no delay.
- R13: After reset every register is 0, no pin is driven and `pin_in` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write word address (bit 4 half, bits 3:0 index) |
| wr_data | input | 32 | Set mask in bits 15:0, clear mask in bits 31:16 |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 32 | Addressed register in bits 15:0 |
| pad_in | input | 32 | Raw pad levels |
| pad_oe | output | 32 | Pad drive enable |
| pad_out | output | 32 | Pad drive level |
| pad_pu | output | 32 | Pull-up request |
| pad_pd | output | 32 | Pull-down request |
| pin_in | output | 32 | Synchronized, inverted and gated input level |

## Verification
Register writes are tried with the following patterns, each followed by a read-back:
- set-only words;
- clear-only words;
- all-zero words;
- words that set and clear the same pin;
- words aimed at the high half;
- words aimed at an unused index.

Together these separate a correct set/clear merge from a plain overwrite, from a merge where set wins, and from decoding that leaks between halves. Pad drive is checked on the same two pins under three settings: plain push-pull, push-pull with the output inverted, and open-drain with the output inverted. This distinguishes inverting before the drive decision from inverting after it. The input path is sampled one and two edges after a pad change, and again after the input inversion is toggled, which pins down both the synchronizer depth and where the inversion sits.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned REG_COUNT = 8;

  typedef enum logic [2:0] {
    REG_LEVEL = 3'd0,
    REG_IEN   = 3'd1,
    REG_OEN   = 3'd2,
    REG_ODRN  = 3'd3,
    REG_PUP   = 3'd4,
    REG_PDN   = 3'd5,
    REG_IINV  = 3'd6,
    REG_OINV  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_pkg::*;
#(
  parameter int unsigned PINS  = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bank_wr,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [2*PINS-1:0]   wr_word,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [PINS-1:0]     rd_word,
  output logic [PINS-1:0]     lvl,
  output logic [PINS-1:0]     ien,
  output logic [PINS-1:0]     oen,
  output logic [PINS-1:0]     odrn,
  output logic [PINS-1:0]     pup,
  output logic [PINS-1:0]     pdn,
  output logic [PINS-1:0]     iinv,
  output logic [PINS-1:0]     oinv
);
  localparam int unsigned REGS = REG_COUNT;

  logic [PINS-1:0] state_q [REGS];

  // set mask in low half, clear mask in upper half; clear dominates
  function automatic logic [PINS-1:0] merge_setclr(input logic [PINS-1:0] cur,
                                                    input logic [2*PINS-1:0] word);
    return (cur | word[PINS-1:0]) & ~word[2*PINS-1:PINS];
  endfunction

  for (genvar r = 0; r < REGS; r++) begin : g_reg
    logic hit;
    assign hit = bank_wr && (wr_idx == IDX_W'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        state_q[r] <= '0;
      end else if (hit) begin
        state_q[r] <= merge_setclr(state_q[r], wr_word);
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int r = 0; r < REGS; r++) begin
      if (rd_idx == IDX_W'(r)) rd_word = state_q[r];
    end
  end

  assign lvl  = state_q[REG_LEVEL];
  assign ien  = state_q[REG_IEN];
  assign oen  = state_q[REG_OEN];
  assign odrn = state_q[REG_ODRN];
  assign pup  = state_q[REG_PUP];
  assign pdn  = state_q[REG_PDN];
  assign iinv = state_q[REG_IINV];
  assign oinv = state_q[REG_OINV];
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int unsigned PINS = 32
) (
  input  logic [PINS-1:0] lvl,
  input  logic [PINS-1:0] oen,
  input  logic [PINS-1:0] odrn,
  input  logic [PINS-1:0] oinv,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_out
);
  // drive decision for one pin: {enable, level}
  function automatic logic [1:0] drive_of(input logic level, input logic en,
                                          input logic od, input logic inv);
    logic eff;
    eff = level ^ inv;
    if (!en)     return 2'b00;
    else if (od) return eff ? 2'b00 : 2'b10;
    else         return {1'b1, eff};
  endfunction

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic [1:0] drv;
    assign drv        = drive_of(lvl[p], oen[p], odrn[p], oinv[p]);
    assign pad_oe[p]  = drv[1];
    assign pad_out[p] = drv[0];
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned PINS   = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pad_in,
  input  logic [PINS-1:0] ien,
  input  logic [PINS-1:0] iinv,
  output logic [PINS-1:0] pin_in
);
  logic [PINS-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= pad_in;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  function automatic logic [PINS-1:0] gate_in(input logic [PINS-1:0] raw,
                                               input logic [PINS-1:0] en,
                                               input logic [PINS-1:0] inv);
    return en & (raw ^ inv);
  endfunction

  assign pin_in = gate_in(chain_q[STAGES-1], ien, iinv);
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int unsigned PINS_PER_BANK = 16,
  parameter int unsigned BANKS         = 2,
  parameter int unsigned BANK_STRIDE   = 16,
  parameter int unsigned SYNC_STAGES   = 2,
  localparam int unsigned PIN_COUNT    = PINS_PER_BANK * BANKS,
  localparam int unsigned DATA_W       = 2 * PINS_PER_BANK,
  localparam int unsigned IDX_W        = $clog2(BANK_STRIDE),
  localparam int unsigned BSEL_W       = $clog2(BANKS),
  localparam int unsigned ADDR_W       = IDX_W + BSEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  input  logic [PIN_COUNT-1:0] pad_in,
  output logic [PIN_COUNT-1:0] pad_oe,
  output logic [PIN_COUNT-1:0] pad_out,
  output logic [PIN_COUNT-1:0] pad_pu,
  output logic [PIN_COUNT-1:0] pad_pd,
  output logic [PIN_COUNT-1:0] pin_in
);
  // named internal events and state, visible to the checker
  logic [BANKS-1:0]         bank_wr;
  logic [PIN_COUNT-1:0]     cfg_lvl, cfg_ien, cfg_oen, cfg_odrn;
  logic [PIN_COUNT-1:0]     cfg_iinv, cfg_oinv;
  logic [PINS_PER_BANK-1:0] bank_rd [BANKS];

  logic [BSEL_W-1:0] wr_bank, rd_bank;
  assign wr_bank = wr_addr[ADDR_W-1:IDX_W];
  assign rd_bank = rd_addr[ADDR_W-1:IDX_W];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_wr[b] = wr_en && (wr_bank == BSEL_W'(b));

    gpio_regbank #(
      .PINS  (PINS_PER_BANK),
      .IDX_W (IDX_W)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .bank_wr (bank_wr[b]),
      .wr_idx  (wr_addr[IDX_W-1:0]),
      .wr_word (wr_data),
      .rd_idx  (rd_addr[IDX_W-1:0]),
      .rd_word (bank_rd[b]),
      .lvl     (cfg_lvl [b*PINS_PER_BANK +: PINS_PER_BANK]),
      .ien     (cfg_ien [b*PINS_PER_BANK +: PINS_PER_BANK]),
      .oen     (cfg_oen [b*PINS_PER_BANK +: PINS_PER_BANK]),
      .odrn    (cfg_odrn[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .pup     (pad_pu  [b*PINS_PER_BANK +: PINS_PER_BANK]),
      .pdn     (pad_pd  [b*PINS_PER_BANK +: PINS_PER_BANK]),
      .iinv    (cfg_iinv[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .oinv    (cfg_oinv[b*PINS_PER_BANK +: PINS_PER_BANK])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (rd_bank == BSEL_W'(b)) rd_data[PINS_PER_BANK-1:0] = bank_rd[b];
    end
  end

  gpio_pad_drive #(.PINS(PIN_COUNT)) u_drive (
    .lvl     (cfg_lvl),
    .oen     (cfg_oen),
    .odrn    (cfg_odrn),
    .oinv    (cfg_oinv),
    .pad_oe  (pad_oe),
    .pad_out (pad_out)
  );

  gpio_in_sync #(.PINS(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_in (pad_in),
    .ien    (cfg_ien),
    .iinv   (cfg_iinv),
    .pin_in (pin_in)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned PINS   = 16,
  parameter int unsigned NPIN   = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [2*PINS-1:0] wr_data,
  input logic [NPIN-1:0]   pad_oe,
  input logic [NPIN-1:0]   pad_out,
  input logic [NPIN-1:0]   pin_in,
  input logic [NPIN-1:0]   cfg_oen,
  input logic [NPIN-1:0]   cfg_odrn,
  input logic [NPIN-1:0]   cfg_ien
);
  localparam logic [ADDR_W-1:0] OEN_LO = ADDR_W'(2);

  // R2
  set_pin0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == OEN_LO && wr_data[0] && !wr_data[PINS] |=> cfg_oen[0]);

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == OEN_LO && wr_data[PINS] |=> !cfg_oen[0]);

  // R4
  keep_pin0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == OEN_LO && !wr_data[0] && !wr_data[PINS] |=> $stable(cfg_oen[0]));

  // R1
  half_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr[ADDR_W-1] |=> $stable(cfg_oen[PINS-1:0]));

  // R9
  undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_out) & ~cfg_oen) == '0);

  // R8
  od_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & cfg_odrn) == '0);

  // R11
  in_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_in & ~cfg_ien) == '0);
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(
  .PINS   (PINS_PER_BANK),
  .NPIN   (PIN_COUNT),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .pad_oe   (pad_oe),
  .pad_out  (pad_out),
  .pin_in   (pin_in),
  .cfg_oen  (cfg_oen),
  .cfg_odrn (cfg_odrn),
  .cfg_ien  (cfg_ien)
);

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_oe, pad_out, pad_pu, pad_pd, pin_in;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  gpio_bank_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .pin_in(pin_in)
  );

  typedef struct packed {
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // write, then read the same address back
  localparam vec_t VECS [12] = '{
    '{5'd2,  32'h0000_0005, 32'h0000_0005, 4'd2},  // R2 set pins 0,2
    '{5'd2,  32'h0001_0000, 32'h0000_0004, 4'd3},  // R3 clear pin 0
    '{5'd2,  32'h0000_0000, 32'h0000_0004, 4'd4},  // R4 empty word
    '{5'd2,  32'h0004_0004, 32'h0000_0000, 4'd5},  // R5 clear wins
    '{5'd0,  32'h0000_8001, 32'h0000_8001, 4'd6},  // R6 level readback
    '{5'd18, 32'h0000_0003, 32'h0000_0003, 4'd1},  // R1 high half
    '{5'd2,  32'h0000_0000, 32'h0000_0000, 4'd1},  // R1 low half untouched
    '{5'd9,  32'h0000_FFFF, 32'h0000_0000, 4'd4},  // R4 unused index
    '{5'd2,  32'h0000_0000, 32'h0000_0000, 4'd4},  // R4 still clear
    '{5'd0,  32'h0000_0000, 32'h0000_8001, 4'd4},  // R4 level kept
    '{5'd20, 32'h0000_F00F, 32'h0000_F00F, 4'd2},  // R2 pull-up high
    '{5'd20, 32'hF000_0000, 32'h0000_000F, 4'd3}   // R3 clear 12..15
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    begin
      logic [31:0] acc = '0;
      for (int a = 0; a < 8; a++) begin
        rd_addr = 5'(a);      #1 acc |= rd_data;
        rd_addr = 5'(a + 16); #1 acc |= rd_data;
      end
      check("R13 regs", acc, 32'h0);
    end
    check("R13 pad_oe", pad_oe | pad_out, 32'h0);
    check("R13 pin_in", pin_in | pad_pu | pad_pd, 32'h0);

    for (int i = 0; i < 12; i++) begin
      wr(VECS[i].addr, VECS[i].data);
      rd_addr = VECS[i].addr;
      #1;
      check($sformatf("R%0d vec%0d", VECS[i].req, i), rd_data, VECS[i].exp);
    end

    // R9 low half: output disabled despite level 0x8001
    check("R9 low undriven", {pad_oe[15:0], pad_out[15:0]}, 32'h0);
    // R12 pulls
    check("R12 pull-up", pad_pu, 32'h000F_0000);
    check("R12 pull-down", pad_pd, 32'h0);

    // R7 push-pull on pins 16,17
    wr(5'd16, 32'h0000_0001);
    check("R7 oe", {30'h0, pad_oe[17:16]}, 32'h3);
    check("R7 level", {30'h0, pad_out[17:16]}, 32'h1);
    wr(5'd23, 32'h0000_0003);
    check("R7 inverted", {30'h0, pad_out[17:16]}, 32'h2);

    // R8 open drain with inversion: pin16 eff 0 drives low, pin17 eff 1 released
    wr(5'd19, 32'h0000_0003);
    check("R8 oe", {30'h0, pad_oe[17:16]}, 32'h1);
    check("R8 level", {30'h0, pad_out[17:16]}, 32'h0);

    // R10 synchronizer depth
    wr(5'd1, 32'h0000_0001);
    pad_in = 32'h0001_0001;
    @(negedge clk);
    check("R10 one edge", {31'h0, pin_in[0]}, 32'h0);
    @(negedge clk);
    check("R10 two edges", {31'h0, pin_in[0]}, 32'h1);
    // R11 pin16 not enabled
    check("R11 disabled", {31'h0, pin_in[16]}, 32'h0);
    // R10 inversion applies at once
    wr(5'd6, 32'h0000_0001);
    check("R10 invert now", {31'h0, pin_in[0]}, 32'h0);
    pad_in = 32'h0;
    repeat (2) @(negedge clk);
    check("R10 invert low", {31'h0, pin_in[0]}, 32'h1);
    // R11 disable input again
    wr(5'd1, 32'h0001_0000);
    check("R11 off", pin_in, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule